// File: doc/BRIEF.md
# Multicycle Register-File Processor Core

This block is a compact multicycle processor core. It reads three-byte instructions one byte at a time from a byte-wide code memory. It decodes each instruction and executes it against a file of eight 32-bit general registers. The supported operations are signed arithmetic, conditional and unconditional branches, register copy, sign-extended constant load, fixed-address data load/store and a handshaked input/output channel. Any illegal condition sets a single sticky halt flag: a stop instruction, a signed arithmetic overflow, a zero divisor or an unknown opcode. The core then freezes until reset.

Every instruction spends three cycles in fetch and one cycle in execute. Channel transfers add cycles until the responder acknowledges. Code and data memories are expected to answer combinationally within the cycle in which the address is presented. The core is intended to sit beside separate stack and heap units that handle the remaining instruction classes.

Top module: `cpu_core`

## Requirements
- R1: An instruction is 24 bits. It is fetched from code bytes pc, pc+1 and pc+2 on three consecutive cycles and assembled most-significant byte first, and pc then advances by 3 (modulo 2^16). Bits [23:19] are the opcode, bits [18:16] the first register index ra, bits [15:0] the address/constant field, and bits [2:0] the second register index rb.
- R2: All eight 32-bit registers read as zero after reset.
- R3: Opcode 0x00 raises halted_o. halted_o stays high until reset, and while it is high no code address change, data access or channel request occurs.
- R4: Opcode 0x05 writes ra+rb into ra, and opcode 0x06 writes ra-rb into ra.
- R5: Opcode 0x07 writes the signed product ra*rb into ra. Opcode 0x08 writes the signed quotient ra/rb, truncated toward zero, into ra.
- R6: A signed 32-bit overflow in any of opcodes 0x05-0x08, or a zero divisor, raises halted_o, and no later instruction executes.
- R7: Opcode 0x09 continues execution at the 16-bit field.
- R8: Opcode 0x0A branches to the 16-bit field when ra is zero. Opcode 0x0B branches there when bit 31 of ra is set. Otherwise execution falls through.
- R9: Opcode 0x0C copies register ra into register rb.
- R10: Opcode 0x13 writes the 16-bit field, sign-extended to 32 bits, into ra.
- R11: Opcode 0x01 pulses dmem_re_o for one cycle at the 16-bit address and writes dmem_rdata_i into ra. Opcode 0x02 pulses dmem_we_o for one cycle with ra on dmem_wdata_o. The two strobes are never high together.
- R12: Opcodes 0x03 (input, io_we_o=0) and 0x04 (output, io_we_o=1) hold io_req_o with io_chan_o equal to the 16-bit field until io_ack_i. An input writes io_rdata_i into ra in the acknowledge cycle, and an output presents ra on io_wdata_o.
- R13: Any opcode outside the set above raises halted_o.
- R14: During reset halted_o is low, code_addr_o is 0 and no data or channel strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_addr_o | output | 16 | Code byte address |
| code_rdata_i | input | 8 | Code byte at code_addr_o |
| dmem_addr_o | output | 16 | Data word address |
| dmem_re_o | output | 1 | Data read strobe |
| dmem_we_o | output | 1 | Data write strobe |
| dmem_wdata_o | output | 32 | Data write value |
| dmem_rdata_i | input | 32 | Data read value |
| io_req_o | output | 1 | Channel request |
| io_we_o | output | 1 | Channel direction, 1 = output |
| io_chan_o | output | 16 | Channel number |
| io_wdata_o | output | 32 | Channel output value |
| io_rdata_i | input | 32 | Channel input value |
| io_ack_i | input | 1 | Channel acknowledge |
| halted_o | output | 1 | Sticky halt flag |

## Verification
Code addresses change every cycle: reset shows byte 0, and the next three falling edges show bytes 1, 2 and then the advanced pc. The bench samples them at exactly those edges. A data store or load strobe is due on the fourth cycle of its instruction, and halted_o is due one edge after the stop, overflow or unknown-opcode execute cycle. The bench therefore logs strobes at every falling edge and compares the log only after halted_o is seen. The channel responder acknowledges two falling edges after a request, so results of an input appear only through a later store or output.

// File: rtl/cpu_core_pkg.sv
package cpu_core_pkg;
  localparam int XLEN   = 32;
  localparam int AW     = 16;
  localparam int NREG   = 8;
  localparam int RIW    = $clog2(NREG);
  localparam int IW     = 24;
  localparam int BW     = 8;
  localparam int OPW    = 5;
  localparam int FLDW   = 16;

  typedef enum logic [OPW-1:0] {
    OP_STOP = 5'h00, OP_LD  = 5'h01, OP_ST  = 5'h02, OP_IN  = 5'h03,
    OP_OUT  = 5'h04, OP_ADD = 5'h05, OP_SUB = 5'h06, OP_MUL = 5'h07,
    OP_DIV  = 5'h08, OP_JMP = 5'h09, OP_JZ  = 5'h0A, OP_JN  = 5'h0B,
    OP_MOV  = 5'h0C, OP_LDC = 5'h13
  } opcode_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV} alu_op_e;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_IO, ST_HALT} state_e;
endpackage

// File: rtl/cpu_fetch.sv
module cpu_fetch #(
  parameter int AW = 16,
  parameter int IW = 24,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_en_i,
  input  logic          jump_en_i,
  input  logic [AW-1:0] jump_addr_i,
  input  logic [BW-1:0] code_rdata_i,
  output logic [AW-1:0] code_addr_o,
  output logic [IW-1:0] ir_o,
  output logic          last_byte_o
);
  localparam int NB = IW / BW;
  localparam int CW = (NB > 1) ? $clog2(NB) : 1;

  logic [AW-1:0] pc_q;
  logic [CW-1:0] idx_q;
  logic [IW-1:0] ir_q;

  assign last_byte_o = (idx_q == CW'(NB - 1));
  assign code_addr_o = pc_q + AW'(idx_q);
  assign ir_o        = ir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      idx_q <= '0;
      ir_q  <= '0;
    end else if (fetch_en_i) begin
      ir_q <= {ir_q[IW-BW-1:0], code_rdata_i};  // MSB first
      if (last_byte_o) begin
        idx_q <= '0;
        pc_q  <= pc_q + AW'(NB);
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else if (jump_en_i) begin
      pc_q <= jump_addr_i;
    end
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int NREG = 8,
  parameter int XLEN = 32,
  localparam int RIW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RIW-1:0]  ra_idx_i,
  input  logic [RIW-1:0]  rb_idx_i,
  output logic [XLEN-1:0] ra_data_o,
  output logic [XLEN-1:0] rb_data_o,
  input  logic            we_i,
  input  logic [RIW-1:0]  wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] regs_q [NREG];
  logic [NREG-1:0] wsel;

  for (genvar g = 0; g < NREG; g++) begin : g_wsel
    assign wsel[g] = we_i && (wa_i == RIW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wsel[i]) regs_q[i] <= wd_i;
    end
  end

  assign ra_data_o = regs_q[ra_idx_i];
  assign rb_data_o = regs_q[rb_idx_i];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output logic            ovf_o
);
  localparam logic [XLEN-1:0] MIN_VAL = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN-1:0]   sum, dif, quo;
  logic [2*XLEN-1:0] prod;
  logic              ovf_add, ovf_sub, ovf_mul, div_zero, div_min;

  assign sum  = a_i + b_i;
  assign dif  = a_i - b_i;
  assign prod = $signed(a_i) * $signed(b_i);

  assign ovf_add  = (a_i[XLEN-1] == b_i[XLEN-1]) && (sum[XLEN-1] != a_i[XLEN-1]);
  assign ovf_sub  = (a_i[XLEN-1] != b_i[XLEN-1]) && (dif[XLEN-1] != a_i[XLEN-1]);
  // upper half plus sign bit must all match
  assign ovf_mul  = !((&prod[2*XLEN-1:XLEN-1]) || !(|prod[2*XLEN-1:XLEN-1]));
  assign div_zero = (b_i == '0);
  assign div_min  = (a_i == MIN_VAL) && (&b_i);
  assign quo      = (div_zero || div_min) ? '0 : XLEN'($signed(a_i) / $signed(b_i));

  always_comb begin
    unique case (op_i)
      ALU_ADD: begin res_o = sum;              ovf_o = ovf_add;             end
      ALU_SUB: begin res_o = dif;              ovf_o = ovf_sub;             end
      ALU_MUL: begin res_o = prod[XLEN-1:0];   ovf_o = ovf_mul;             end
      default: begin res_o = quo;              ovf_o = div_zero || div_min; end
    endcase
  end
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_core_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [AW-1:0]   code_addr_o,
  input  logic [BW-1:0]   code_rdata_i,
  output logic [AW-1:0]   dmem_addr_o,
  output logic            dmem_re_o,
  output logic            dmem_we_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  input  logic [XLEN-1:0] dmem_rdata_i,
  output logic            io_req_o,
  output logic            io_we_o,
  output logic [FLDW-1:0] io_chan_o,
  output logic [XLEN-1:0] io_wdata_o,
  input  logic [XLEN-1:0] io_rdata_i,
  input  logic            io_ack_i,
  output logic            halted_o
);
  state_e          state_q, state_d;
  logic [IW-1:0]   ir;
  opcode_e         op;
  logic [RIW-1:0]  ra_idx, rb_idx, wa;
  logic [FLDW-1:0] fld;
  logic [XLEN-1:0] ra_data, rb_data, wd, alu_res;
  alu_op_e         alu_op;
  logic            fetch_en, last_byte, jump_en, rf_we, alu_ovf, is_arith, ovf_trap;

  assign op     = opcode_e'(ir[IW-1 -: OPW]);
  assign ra_idx = ir[IW-OPW-1 -: RIW];
  assign fld    = ir[FLDW-1:0];
  assign rb_idx = fld[RIW-1:0];
  assign alu_op = alu_op_e'(2'(ir[IW-1 -: OPW] - OP_ADD));
  assign is_arith = op inside {OP_ADD, OP_SUB, OP_MUL, OP_DIV};

  assign fetch_en = (state_q == ST_FETCH);
  assign ovf_trap = (state_q == ST_EXEC) && is_arith && alu_ovf;

  cpu_fetch #(.AW(AW), .IW(IW), .BW(BW)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_en_i  (fetch_en),
    .jump_en_i   (jump_en),
    .jump_addr_i (fld),
    .code_rdata_i(code_rdata_i),
    .code_addr_o (code_addr_o),
    .ir_o        (ir),
    .last_byte_o (last_byte)
  );

  cpu_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_idx_i (ra_idx),
    .rb_idx_i (rb_idx),
    .ra_data_o(ra_data),
    .rb_data_o(rb_data),
    .we_i     (rf_we),
    .wa_i     (wa),
    .wd_i     (wd)
  );

  cpu_alu #(.XLEN(XLEN)) u_alu (
    .op_i (alu_op),
    .a_i  (ra_data),
    .b_i  (rb_data),
    .res_o(alu_res),
    .ovf_o(alu_ovf)
  );

  always_comb begin
    state_d   = state_q;
    rf_we     = 1'b0;
    wa        = ra_idx;
    wd        = alu_res;
    jump_en   = 1'b0;
    dmem_re_o = 1'b0;
    dmem_we_o = 1'b0;
    io_req_o  = 1'b0;
    unique case (state_q)
      ST_FETCH: if (last_byte) state_d = ST_EXEC;
      ST_EXEC: begin
        state_d = ST_FETCH;
        case (op)
          OP_STOP: state_d = ST_HALT;
          OP_LD: begin
            dmem_re_o = 1'b1;
            rf_we     = 1'b1;
            wd        = dmem_rdata_i;
          end
          OP_ST:  dmem_we_o = 1'b1;
          OP_IN, OP_OUT: state_d = ST_IO;
          OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
            if (alu_ovf) state_d = ST_HALT;
            else         rf_we   = 1'b1;
          end
          OP_JMP: jump_en = 1'b1;
          OP_JZ:  jump_en = (ra_data == '0);
          OP_JN:  jump_en = ra_data[XLEN-1];
          OP_MOV: begin
            rf_we = 1'b1;
            wa    = rb_idx;
            wd    = ra_data;
          end
          OP_LDC: begin
            rf_we = 1'b1;
            wd    = {{(XLEN-FLDW){fld[FLDW-1]}}, fld};
          end
          default: state_d = ST_HALT;
        endcase
      end
      ST_IO: begin
        io_req_o = 1'b1;
        if (io_ack_i) begin
          state_d = ST_FETCH;
          if (op == OP_IN) begin
            rf_we = 1'b1;
            wd    = io_rdata_i;
          end
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign dmem_addr_o  = fld;
  assign dmem_wdata_o = ra_data;
  assign io_we_o      = (op == OP_OUT);
  assign io_chan_o    = fld;
  assign io_wdata_o   = ra_data;
  assign halted_o     = (state_q == ST_HALT);
endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        halted_o,
  input logic        dmem_we_o,
  input logic        dmem_re_o,
  input logic        io_req_o,
  input logic        io_ack_i,
  input logic        io_we_o,
  input logic [15:0] io_chan_o,
  input logic [15:0] code_addr_o,
  input logic        fetch_en,
  input logic        last_byte,
  input logic        ovf_trap
);
  AST_FETCH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en && !last_byte |=> code_addr_o == $past(code_addr_o) + 16'd1); // R1
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(code_addr_o)); // R3
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !dmem_we_o && !dmem_re_o && !io_req_o); // R3
  AST_OVF_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_trap |=> halted_o); // R6
  AST_MEM_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dmem_we_o && dmem_re_o)); // R11
  AST_IO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_req_o && !io_ack_i |=> io_req_o && $stable(io_chan_o) && $stable(io_we_o)); // R12
endmodule

bind cpu_core cpu_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .halted_o   (halted_o),
  .dmem_we_o  (dmem_we_o),
  .dmem_re_o  (dmem_re_o),
  .io_req_o   (io_req_o),
  .io_ack_i   (io_ack_i),
  .io_we_o    (io_we_o),
  .io_chan_o  (io_chan_o),
  .code_addr_o(code_addr_o),
  .fetch_en   (fetch_en),
  .last_byte  (last_byte),
  .ovf_trap   (ovf_trap)
);

// File: tb/sim_cpu_core.sv
module sim_cpu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] code_addr, dmem_addr, io_chan;
  logic [7:0]  code_rdata;
  logic        dmem_re, dmem_we, io_req, io_we, halted;
  logic [31:0] dmem_wdata, dmem_rdata, io_wdata;
  logic [31:0] io_rdata = '0;
  logic        io_ack = 1'b0;

  logic [7:0]  cmem [1024];
  logic [31:0] dmem [256];
  logic [15:0] st_addr [16];
  logic [31:0] st_data [16];
  int          st_n;
  logic [15:0] out_chan [8];
  logic [31:0] out_data [8];
  int          out_n;
  int          io_cnt;
  int          n_chk = 0, n_bad = 0, gcyc = 0;

  always #10 clk = ~clk;  // 50 MHz

  cpu_core u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .code_addr_o(code_addr), .code_rdata_i(code_rdata),
    .dmem_addr_o(dmem_addr), .dmem_re_o(dmem_re), .dmem_we_o(dmem_we),
    .dmem_wdata_o(dmem_wdata), .dmem_rdata_i(dmem_rdata),
    .io_req_o(io_req), .io_we_o(io_we), .io_chan_o(io_chan),
    .io_wdata_o(io_wdata), .io_rdata_i(io_rdata), .io_ack_i(io_ack),
    .halted_o(halted)
  );

  assign code_rdata = cmem[code_addr[9:0]];
  assign dmem_rdata = dmem[dmem_addr[7:0]];

  always @(negedge clk) begin
    if (rst_n && dmem_we) begin
      if (st_n < 16) begin st_addr[st_n] = dmem_addr; st_data[st_n] = dmem_wdata; end
      st_n++;
      dmem[dmem_addr[7:0]] = dmem_wdata;
    end
    if (!rst_n) begin
      io_ack = 1'b0; io_cnt = 0;
    end else if (io_req && !io_ack) begin
      io_cnt++;
      if (io_cnt >= 2) begin
        io_ack   = 1'b1;
        io_rdata = 32'hC0DE_0000 | {16'h0, io_chan};
        if (io_we) begin
          if (out_n < 8) begin out_chan[out_n] = io_chan; out_data[out_n] = io_wdata; end
          out_n++;
        end
      end
    end else if (!io_req) begin
      io_ack = 1'b0; io_cnt = 0;
    end
  end

  always @(posedge clk) begin
    gcyc++;
    if (gcyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected < 150000", gcyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [23:0] ins(input logic [4:0] op, input logic [2:0] r, input logic [15:0] f);
    return {op, r, f};
  endfunction

  task automatic put(input int i, input logic [23:0] w);
    cmem[3*i] = w[23:16]; cmem[3*i+1] = w[15:8]; cmem[3*i+2] = w[7:0];
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 1024; i++) cmem[i] = 8'h00;
    for (int i = 0; i < 256; i++) dmem[i] = 32'h0;
  endtask

  task automatic run(input int max);
    int c;
    @(negedge clk);
    rst_n = 1'b0; st_n = 0; out_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    c = 0;
    while (!halted && c < max) begin @(negedge clk); c++; end
  endtask

  task automatic chk_store(input string req, input int k, input logic [15:0] a, input logic [31:0] d);
    chk(req, 32'(st_addr[k]), 32'(a));
    chk(req, st_data[k], d);
  endtask

  // R14, R1: reset values and fetch byte order
  task automatic t_reset_fetch();
    clear_prog();
    put(0, ins(5'h13, 3'd1, 16'd1));
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R14 halted in reset", 32'(halted), 0);
    chk("R14 code_addr in reset", 32'(code_addr), 0);
    chk("R14 strobes in reset", {29'h0, dmem_we, dmem_re, io_req}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 byte0 addr", 32'(code_addr), 0);
    @(negedge clk); chk("R1 byte1 addr", 32'(code_addr), 1);
    @(negedge clk); chk("R1 byte2 addr", 32'(code_addr), 2);
    @(negedge clk);
    @(negedge clk); chk("R1 next pc", 32'(code_addr), 3);
  endtask

  // R3: stop halts and stays halted
  task automatic t_stop();
    clear_prog();
    run(50);
    chk("R3 halted", 32'(halted), 1);
    repeat (20) @(negedge clk);
    chk("R3 still halted", 32'(halted), 1);
    chk("R3 pc frozen", 32'(code_addr), 3);
    chk("R3 no access", 32'(st_n + out_n), 0);
  endtask

  // R2, R11: reset register value, load and store
  task automatic t_ldst();
    clear_prog();
    dmem[5] = 32'hDEAD_BEEF;
    put(0, ins(5'h02, 3'd5, 16'h0008));
    put(1, ins(5'h01, 3'd3, 16'h0005));
    put(2, ins(5'h02, 3'd3, 16'h0009));
    run(100);
    chk("R11 store count", st_n, 2);
    chk_store("R2 reset register zero", 0, 16'h0008, 32'h0);
    chk_store("R11 load then store", 1, 16'h0009, 32'hDEAD_BEEF);
  endtask

  // R10, R4: constant load, add, subtract
  task automatic t_addsub();
    clear_prog();
    put(0, ins(5'h13, 3'd1, 16'd100));
    put(1, ins(5'h13, 3'd2, 16'hFFF9));
    put(2, ins(5'h02, 3'd2, 16'h0021));
    put(3, ins(5'h05, 3'd1, 16'd2));
    put(4, ins(5'h02, 3'd1, 16'h0020));
    put(5, ins(5'h06, 3'd2, 16'd1));
    put(6, ins(5'h02, 3'd2, 16'h0022));
    run(200);
    chk("R4 store count", st_n, 3);
    chk_store("R10 sign extend", 0, 16'h0021, 32'hFFFF_FFF9);
    chk_store("R4 add", 1, 16'h0020, 32'd93);
    chk_store("R4 sub", 2, 16'h0022, 32'hFFFF_FF9C);
  endtask

  // R5: multiply and truncating divide
  task automatic t_muldiv();
    clear_prog();
    put(0, ins(5'h13, 3'd1, 16'hFFF9));
    put(1, ins(5'h13, 3'd2, 16'd2));
    put(2, ins(5'h08, 3'd1, 16'd2));
    put(3, ins(5'h02, 3'd1, 16'h0010));
    put(4, ins(5'h13, 3'd3, 16'd7));
    put(5, ins(5'h13, 3'd4, 16'hFFFE));
    put(6, ins(5'h08, 3'd3, 16'd4));
    put(7, ins(5'h02, 3'd3, 16'h0011));
    put(8, ins(5'h13, 3'd5, 16'hFED4));
    put(9, ins(5'h07, 3'd5, 16'd2));
    put(10, ins(5'h02, 3'd5, 16'h0012));
    run(300);
    chk("R5 store count", st_n, 3);
    chk_store("R5 div -7/2", 0, 16'h0010, 32'hFFFF_FFFD);
    chk_store("R5 div 7/-2", 1, 16'h0011, 32'hFFFF_FFFD);
    chk_store("R5 mul -300*2", 2, 16'h0012, 32'hFFFF_FDA8);
  endtask

  // R6: overflow and zero divisor halt
  task automatic t_overflow();
    clear_prog();
    put(0, ins(5'h13, 3'd1, 16'h4000));
    put(1, ins(5'h07, 3'd1, 16'd1));
    put(2, ins(5'h13, 3'd2, 16'd8));
    put(3, ins(5'h07, 3'd1, 16'd2));
    put(4, ins(5'h02, 3'd1, 16'h0003));
    run(200);
    chk("R6 mul ovf halted", 32'(halted), 1);
    chk("R6 mul ovf no store", st_n, 0);

    clear_prog();
    put(0, ins(5'h13, 3'd1, 16'h4000));
    put(1, ins(5'h07, 3'd1, 16'd1));
    put(2, ins(5'h13, 3'd2, 16'd4));
    put(3, ins(5'h07, 3'd1, 16'd2));
    put(4, ins(5'h02, 3'd1, 16'h0004));
    put(5, ins(5'h05, 3'd1, 16'd1));
    put(6, ins(5'h02, 3'd1, 16'h0005));
    run(200);
    chk("R6 add ovf stores", st_n, 1);
    chk_store("R6 before add ovf", 0, 16'h0004, 32'h4000_0000);

    clear_prog();
    put(0, ins(5'h13, 3'd1, 16'd5));
    put(1, ins(5'h08, 3'd1, 16'd2));
    put(2, ins(5'h02, 3'd1, 16'h0006));
    run(200);
    chk("R6 div zero halted", 32'(halted), 1);
    chk("R6 div zero no store", st_n, 0);
  endtask

  // R7, R8: jumps
  task automatic t_branch();
    clear_prog();
    put(0, ins(5'h13, 3'd1, 16'd0));
    put(1, ins(5'h13, 3'd2, 16'd5));
    put(2, ins(5'h13, 3'd3, 16'hFFFF));
    put(3, ins(5'h09, 3'd0, 16'd15));
    put(4, ins(5'h02, 3'd2, 16'h0040));
    put(5, ins(5'h0A, 3'd2, 16'd21));
    put(6, ins(5'h02, 3'd2, 16'h0041));
    put(7, ins(5'h0A, 3'd1, 16'd27));
    put(8, ins(5'h02, 3'd2, 16'h0042));
    put(9, ins(5'h0B, 3'd2, 16'd33));
    put(10, ins(5'h02, 3'd1, 16'h0043));
    put(11, ins(5'h0B, 3'd3, 16'd39));
    put(12, ins(5'h02, 3'd2, 16'h0044));
    put(13, ins(5'h02, 3'd3, 16'h0045));
    run(300);
    chk("R7 R8 store count", st_n, 3);
    chk_store("R7 jump skipped, R8 jz not taken", 0, 16'h0041, 32'd5);
    chk_store("R8 jz taken, jn not taken", 1, 16'h0043, 32'd0);
    chk_store("R8 jn taken", 2, 16'h0045, 32'hFFFF_FFFF);
  endtask

  // R9: move
  task automatic t_move();
    clear_prog();
    put(0, ins(5'h13, 3'd1, 16'd55));
    put(1, ins(5'h0C, 3'd1, 16'd4));
    put(2, ins(5'h02, 3'd4, 16'h0050));
    put(3, ins(5'h02, 3'd1, 16'h0051));
    run(100);
    chk("R9 store count", st_n, 2);
    chk_store("R9 destination", 0, 16'h0050, 32'd55);
    chk_store("R9 source kept", 1, 16'h0051, 32'd55);
  endtask

  // R12: channel input and output
  task automatic t_io();
    clear_prog();
    put(0, ins(5'h03, 3'd2, 16'h0012));
    put(1, ins(5'h04, 3'd2, 16'h0034));
    run(100);
    chk("R12 output count", out_n, 1);
    chk("R12 output channel", 32'(out_chan[0]), 32'h34);
    chk("R12 input value out", out_data[0], 32'hC0DE_0012);
  endtask

  // R13: unknown opcode
  task automatic t_illegal();
    clear_prog();
    put(0, ins(5'h13, 3'd1, 16'd9));
    put(1, ins(5'h1F, 3'd1, 16'd0));
    put(2, ins(5'h02, 3'd1, 16'h0060));
    run(100);
    chk("R13 halted", 32'(halted), 1);
    chk("R13 no store", st_n, 0);
  endtask

  initial begin
    st_n = 0; out_n = 0; io_cnt = 0;
    t_reset_fetch();
    t_stop();
    t_ldst();
    t_addsub();
    t_muldiv();
    t_overflow();
    t_branch();
    t_move();
    t_io();
    t_illegal();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule